// File: doc/BRIEF.md
# Configurable I/O Port Controller

This block is an eight-pin bidirectional port that sits between a processor bus and a set of pads. Each pin can be a processor-driven general-purpose I/O or carry a signal produced by neighbouring programmable logic. The processor uses a small register bus (address, write strobe, read strobe, write data, read data). Through it, the processor sets the output values, sets the pin directions, selects the input capture behaviour and reads the pin levels.

Every pin has a pad driver. The driver is switched on when either the pin's direction bit or the logic-supplied enable for that pin is high. A per-pin source select chooses whether the driven value comes from the processor's output register or from the logic's output. On the input side, each pin passes through a capture cell. The cell is programmed as a clocked capture register, a transparent latch or a straight wire, and a logic-generated capture enable qualifies it. The captured values go out on a bus towards the logic, and the processor can read them too.

Register offsets: 0 is pin levels (read-only), 1 is output data, 2 is direction, 3 and 4 are capture modes, and 5 is capture outputs (read-only). Pin n's capture mode is bits [2n+1:2n] of a 16-bit word. The low byte of that word sits at offset 3 and the high byte at offset 4. The mode codes are 00 pass-through, 01 register and 10 latch; 11 acts as pass-through.

Top module: `io_port_ctrl`

## Requirements
- R1: After reset the output-data, direction and capture-mode registers read 0, no pin driver is enabled, and every capture cell is in pass-through.
- R2: Pin n's driver is enabled exactly when direction bit n or `pld_oe[n]` is 1. With `pld_oe[n]` at 0, the direction bit alone decides.
- R3: An enabled pin n drives `pld_out[n]` when `pin_sel[n]` is 1, and bit n of the output-data register when `pin_sel[n]` is 0.
- R4: A write to offset 1, 2, 3 or 4 updates that register at the clock edge where `bus_wr` is sampled high. A read returns the register contents on `bus_rdata` after the clock edge where `bus_rd` is sampled high.
- R5: Writes to offsets 0, 5, 6 and 7 change no register.
- R6: A read of offset 0 returns the current level of each pad, bit n for pin n, whether the pad is driven by this block or from outside.
- R7: In pass-through mode (00), capture output n follows pad n with no clock delay.
- R8: In register mode (01), capture output n takes pad n's value at a clock edge where `cap_en` is 1, and holds it while `cap_en` is 0.
- R9: In latch mode (10), capture output n follows pad n while `cap_en` is 1. While `cap_en` is 0 it shows the value pad n had at the last clock edge with `cap_en` at 1.
- R10: Capture outputs appear on `cap_bus` and read back at offset 5.
- R11: Each pin's mode, direction and source select act on that pin only. Pins set to different modes behave independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pld_out | input | 8 | Logic-supplied output values |
| pld_oe | input | 8 | Logic-supplied driver enables |
| pin_sel | input | 8 | Per-pin source select, 1 = logic value |
| cap_en | input | 1 | Logic-generated capture enable |
| cap_bus | output | 8 | Capture cell outputs towards the logic |
| pin_oe | output | 8 | Driver enable per pin, for observation |
| pad | inout | 8 | Tri-state pins |

## Verification
Register writes take effect at the edge that samples `bus_wr`, and their effect on driver enables and pad values appears in that same cycle. Read data is due one edge after `bus_rd` is sampled. Pass-through and an open latch respond to the pad with no clock delay, and register-mode capture updates only at an edge that samples `cap_en` high. The bench changes inputs on falling edges, and it samples combinational paths one nanosecond after the change and registered results at the next falling edge.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

    typedef enum logic [1:0] {
        CAP_PASS  = 2'b00,
        CAP_REG   = 2'b01,
        CAP_LATCH = 2'b10,
        CAP_RSVD  = 2'b11
    } cap_mode_e;

    localparam int unsigned OFS_PINS    = 0;
    localparam int unsigned OFS_DOUT    = 1;
    localparam int unsigned OFS_DIR     = 2;
    localparam int unsigned OFS_MODE_LO = 3;
    localparam int unsigned OFS_MODE_HI = 4;
    localparam int unsigned OFS_CAP     = 5;

endpackage

// File: rtl/io_port_regs.sv
module io_port_regs
    import io_port_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pad_in,
    input  logic [W-1:0]      cap_out,
    output logic [W-1:0]      dout,
    output logic [W-1:0]      dir,
    output logic [2*W-1:0]    mode,
    output logic [W-1:0]      rdata
);

    localparam int unsigned MW = 2 * W;

    typedef struct packed {
        logic [W-1:0]  dout;
        logic [W-1:0]  dir;
        logic [MW-1:0] mode;
        logic [W-1:0]  rdata;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (addr)
                AW'(OFS_DOUT):    st_d.dout         = wdata;
                AW'(OFS_DIR):     st_d.dir          = wdata;
                AW'(OFS_MODE_LO): st_d.mode[W-1:0]  = wdata;
                AW'(OFS_MODE_HI): st_d.mode[MW-1:W] = wdata;
                default:          ;
            endcase
        end
        if (rd) begin
            case (addr)
                AW'(OFS_PINS):    st_d.rdata = pad_in;
                AW'(OFS_DOUT):    st_d.rdata = st_q.dout;
                AW'(OFS_DIR):     st_d.rdata = st_q.dir;
                AW'(OFS_MODE_LO): st_d.rdata = st_q.mode[W-1:0];
                AW'(OFS_MODE_HI): st_d.rdata = st_q.mode[MW-1:W];
                AW'(OFS_CAP):     st_d.rdata = cap_out;
                default:          st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.dout;
    assign dir   = st_q.dir;
    assign mode  = st_q.mode;
    assign rdata = st_q.rdata;

    // R1: registers come out of reset cleared
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout == '0 && dir == '0 && mode == '0));

    // R4: a write to the output register lands at the next edge
    a_r4_dout_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == AW'(OFS_DOUT)) |=> (dout == $past(wdata)));

    // R4: a write to the direction register lands at the next edge
    a_r4_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == AW'(OFS_DIR)) |=> (dir == $past(wdata)));

    // R5: writes outside the writable offsets leave every register alone
    a_r5_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == AW'(OFS_PINS) || addr > AW'(OFS_MODE_HI)))
        |=> ($stable(dout) && $stable(dir) && $stable(mode)));

endmodule

// File: rtl/io_port_capture.sv
module io_port_capture
    import io_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   pad_in,
    input  logic           cap_en,
    input  logic [2*W-1:0] mode,
    output logic [W-1:0]   cap_out
);

    logic [W-1:0] held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (cap_en) held_d = pad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_cell
        cap_mode_e m;
        assign m = cap_mode_e'(mode[2*i +: 2]);
        assign cap_out[i] = (m == CAP_REG)                ? held_q[i] :
                            (m == CAP_LATCH && !cap_en)   ? held_q[i] :
                                                            pad_in[i];
    end

    // R8: stored capture values only move when the enable is high
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(held_q));

endmodule

// File: rtl/io_port_drive.sv
module io_port_drive #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] pld_oe,
    input  logic [W-1:0] pld_out,
    input  logic [W-1:0] pin_sel,
    output logic [W-1:0] oe,
    output logic [W-1:0] val
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign oe[i]  = dir[i] | pld_oe[i];
        assign val[i] = pin_sel[i] ? pld_out[i] : dout[i];
    end

endmodule

// File: rtl/io_port_ctrl.sv
module io_port_ctrl #(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pld_out,
    input  logic [W-1:0]  pld_oe,
    input  logic [W-1:0]  pin_sel,
    input  logic          cap_en,
    output logic [W-1:0]  cap_bus,
    output logic [W-1:0]  pin_oe,
    inout  wire  [W-1:0]  pad
);

    localparam int unsigned MW = 2 * W;

    logic [W-1:0]  dout, dir, oe, val, pad_in, cap_out;
    logic [MW-1:0] mode;

    assign pad_in = pad;

    io_port_regs #(.W(W), .AW(AW)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .pad_in  (pad_in),
        .cap_out (cap_out),
        .dout    (dout),
        .dir     (dir),
        .mode    (mode),
        .rdata   (bus_rdata)
    );

    io_port_capture #(.W(W)) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .cap_en  (cap_en),
        .mode    (mode),
        .cap_out (cap_out)
    );

    io_port_drive #(.W(W)) i_drive (
        .dir     (dir),
        .dout    (dout),
        .pld_oe  (pld_oe),
        .pld_out (pld_out),
        .pin_sel (pin_sel),
        .oe      (oe),
        .val     (val)
    );

    for (genvar i = 0; i < W; i++) begin : g_pad
        assign pad[i] = oe[i] ? val[i] : 1'bz;
    end

    assign cap_bus = cap_out;
    assign pin_oe  = oe;

    // R2: a logic enable always reaches the driver
    a_r2_logic_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (pld_oe & ~pin_oe) == '0);

    // R2: with no enable from either source the driver stays off
    a_r2_both_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~pld_oe & ~dir) == '0);

endmodule

// File: tb/test_io_port_ctrl.sv
module test_io_port_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pld_out = '0;
    logic [7:0] pld_oe = '0;
    logic [7:0] pin_sel = '0;
    logic       cap_en = 1'b0;
    logic [7:0] cap_bus;
    logic [7:0] pin_oe;
    wire  [7:0] pad;
    logic [7:0] ext_oe = '0;
    logic [7:0] ext_val = '0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_ext
        assign pad[i] = ext_oe[i] ? ext_val[i] : 1'bz;
    end

    io_port_ctrl i_io_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pld_out(pld_out), .pld_oe(pld_oe), .pin_sel(pin_sel),
        .cap_en(cap_en), .cap_bus(cap_bus), .pin_oe(pin_oe), .pad(pad)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        ext_oe = 8'hFF; ext_val = 8'h6C;
        #1;
        check("R1 driver enables", pin_oe, 8'h00);
        check("R1/R7 pass-through after reset", cap_bus, 8'h6C);
        bus_read(3'd1, r); check("R1 output register", r, 8'h00);
        bus_read(3'd2, r); check("R1 direction", r, 8'h00);
        bus_read(3'd3, r); check("R1 mode low", r, 8'h00);
        bus_read(3'd4, r); check("R1 mode high", r, 8'h00);
        ext_oe = 8'h00;
    endtask

    task automatic t_regs();
        logic [7:0] r;
        ext_oe = 8'hF0; ext_val = 8'h90;
        bus_write(3'd1, 8'hA5);
        bus_write(3'd2, 8'h0F);
        bus_read(3'd1, r); check("R4 output readback", r, 8'hA5);
        bus_read(3'd2, r); check("R4 direction readback", r, 8'h0F);
        check("R2 enables from direction", pin_oe, 8'h0F);
        check("R3/R6 pad levels", pad, 8'h95);
        bus_read(3'd0, r); check("R6 pin read mixed", r, 8'h95);
        bus_write(3'd3, 8'h12); bus_write(3'd4, 8'h34);
        bus_read(3'd3, r); check("R4 mode low readback", r, 8'h12);
        bus_read(3'd4, r); check("R4 mode high readback", r, 8'h34);
        bus_write(3'd3, 8'h00); bus_write(3'd4, 8'h00);
        ext_oe = 8'h00;
    endtask

    task automatic t_oe_or();
        @(negedge clk);
        pld_oe = 8'hF0; pld_out = 8'h30; pin_sel = 8'hF0;
        #1;
        check("R2 OR of enables", pin_oe, 8'hFF);
        check("R3 mixed value source", pad, 8'h35);
        pin_sel = 8'h00;
        #1;
        check("R3 output register source", pad, 8'hA5);
        pld_oe = 8'h00;
        bus_write(3'd2, 8'h00);
        #1;
        check("R2 all drivers off", pin_oe, 8'h00);
        pld_oe = 8'h04; pin_sel = 8'h04; pld_out = 8'h00;
        #1;
        check("R11 single logic-driven pin", pin_oe, 8'h04);
        check("R11 single pin value", pad[2] ? 8'h01 : 8'h00, 8'h00);
        pld_oe = 8'h00; pin_sel = 8'h00;
    endtask

    task automatic t_ro();
        logic [7:0] r;
        bus_write(3'd0, 8'hFF);
        bus_write(3'd5, 8'hFF);
        bus_write(3'd6, 8'hFF);
        bus_write(3'd7, 8'hFF);
        bus_read(3'd1, r); check("R5 output untouched", r, 8'hA5);
        bus_read(3'd2, r); check("R5 direction untouched", r, 8'h00);
        bus_read(3'd3, r); check("R5 mode low untouched", r, 8'h00);
        bus_read(3'd4, r); check("R5 mode high untouched", r, 8'h00);
        check("R5 drivers untouched", pin_oe, 8'h00);
    endtask

    task automatic t_datain();
        logic [7:0] r;
        ext_oe = 8'hFF; ext_val = 8'h3C;
        bus_read(3'd0, r); check("R6 external levels", r, 8'h3C);
        ext_val = 8'hC3;
        bus_read(3'd0, r); check("R6 external levels changed", r, 8'hC3);
    endtask

    task automatic t_capture();
        logic [7:0] r;
        ext_oe = 8'hFF; ext_val = 8'h11;
        bus_write(3'd3, 8'h55); bus_write(3'd4, 8'h55);
        #1;
        check("R8 held reset value", cap_bus, 8'h00);
        @(negedge clk); cap_en = 1'b1;
        @(negedge clk); cap_en = 1'b0;
        ext_val = 8'h22;
        #1;
        check("R8 captured at enabled edge", cap_bus, 8'h11);
        bus_read(3'd5, r); check("R10 capture readback", r, 8'h11);
        check("R8 holds while disabled", cap_bus, 8'h11);
        bus_write(3'd3, 8'hAA); bus_write(3'd4, 8'hAA);
        #1;
        check("R9 latch closed shows stored", cap_bus, 8'h11);
        @(negedge clk); cap_en = 1'b1; ext_val = 8'h33;
        #1;
        check("R9 latch open follows pad", cap_bus, 8'h33);
        ext_val = 8'h44;
        @(negedge clk); cap_en = 1'b0;
        #1;
        check("R9 latch closed keeps last", cap_bus, 8'h44);
        ext_val = 8'h55;
        #1;
        check("R9 latch ignores pad when closed", cap_bus, 8'h44);
        bus_write(3'd3, 8'h01); bus_write(3'd4, 8'h00);
        ext_val = 8'h00;
        @(negedge clk); cap_en = 1'b1;
        @(negedge clk); cap_en = 1'b0;
        ext_val = 8'hFF;
        #1;
        check("R11/R7 mixed modes", cap_bus, 8'hFE);
        bus_read(3'd5, r); check("R10 mixed readback", r, 8'hFE);
        ext_oe = 8'h00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_oe_or();
        t_ro();
        t_datain();
        t_capture();
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule